// File: doc/BRIEF.md
# Packed-Link Call and Return Stack

This unit sits beside the fetch logic of a small processor core and turns call and return strobes into program-counter redirects. On a call it assembles one 32-bit link word holding the zero flag, the carry flag, the 15-bit call target and the 15-bit address that follows the calling instruction. It stores that word on a stack kept in local registers and redirects fetch to the target, which it takes back out of the stored word.

On a return it removes the newest link word and redirects fetch to the return address held in that word. A configuration input chooses whether the zero and carry flags saved in the word are handed back to the core. A push onto a full stack or a pop from an empty one is refused and sets a sticky error flag. Only a synchronous reset clears that flag. Instruction decode and the datapath are outside this unit.

Top module: `link_stack_unit`

## Requirements
- R1: The link word holds Z in bit 31, C in bit 30, the call target in bits 29:15 and the return address in bits 14:0. A later return gives back the Z, C and return address that were captured at the call.
- R2: One cycle after `call_req` is accepted on a stack that is not full, `next_pc_valid` is 1 and `next_pc` equals the `call_target` of that call.
- R3: The return address is `cur_pc + 1` modulo 2^15, so a call made at PC 0x7FFF returns to 0x0000.
- R4: Calls write at the stack pointer and then increment it. Returns decrement the pointer and then read, so returns take entries in last-in, first-out order.
- R5: When `restore_flags_en` is 1 at a return, `flags_load` is 1 in the following cycle and `flag_z_out`/`flag_c_out` carry the saved Z and C. When it is 0, `flags_load` stays 0 and both flag outputs keep their previous values.
- R6: A call when DEPTH entries are stored is refused. `next_pc_valid` stays 0 in the next cycle, `stack_err` becomes 1, and the stored entries are unchanged.
- R7: A return on an empty stack is refused. `next_pc_valid` stays 0 in the next cycle and `stack_err` becomes 1.
- R8: Once set, `stack_err` stays at 1 until reset, whatever calls and returns follow.
- R9: If `call_req` and `ret_req` are both 1 in the same cycle, the call is performed and the return is ignored.
- R10: A synchronous reset empties the stack, clears `stack_err`, `next_pc_valid` and `flags_load`, and sets both flag outputs to 0.
- R11: In a cycle after neither a call nor a return was performed, `next_pc_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| call_req | input | 1 | Call strobe |
| ret_req | input | 1 | Return strobe |
| call_target | input | 15 | Subroutine entry address |
| cur_pc | input | 15 | Address of the calling instruction |
| flag_z_in | input | 1 | Current zero flag |
| flag_c_in | input | 1 | Current carry flag |
| restore_flags_en | input | 1 | Hand saved flags back on return |
| next_pc | output | 15 | Redirect address |
| next_pc_valid | output | 1 | Redirect strobe |
| flags_load | output | 1 | Restored flags are valid this cycle |
| flag_z_out | output | 1 | Restored zero flag |
| flag_c_out | output | 1 | Restored carry flag |
| stack_err | output | 1 | Sticky overflow/underflow flag |

## Verification
The assertions check on every cycle that an accepted call redirects to its own target, that the pointer never passes DEPTH, and that the refused-push and refused-pop cases raise the error without a redirect. They also check that the error stays set, that disabled restore leaves the flags alone, and that reset clears the state. Other behaviour can only be shown by scenarios in the bench: the bit packing recovered through returns, the wrap of the return address, the last-in, first-out order across a full stack, and the priority of a call over a simultaneous return.

// File: rtl/link_pkg.sv
package link_pkg;
    localparam int ADDR_W = 15;
    localparam int LINK_W = 2 * ADDR_W + 2;

    typedef logic [ADDR_W-1:0] addr_t;

    // Field order is fixed: bit 31 Z, bit 30 C, target, return address
    typedef struct packed {
        logic  z;
        logic  c;
        addr_t target;
        addr_t ret;
    } link_word_t;

    function automatic link_word_t build_link(logic z, logic c, addr_t tgt, addr_t pc);
        link_word_t w;
        w.z      = z;
        w.c      = c;
        w.target = tgt;
        w.ret    = pc + addr_t'(1);
        return w;
    endfunction

    function automatic addr_t target_of(link_word_t w);
        logic [LINK_W-1:0] s;
        s = LINK_W'(w) >> ADDR_W;
        return s[ADDR_W-1:0];
    endfunction
endpackage

// File: rtl/link_stack_rf.sv
module link_stack_rf
    import link_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       push,
    input  logic       pop,
    input  link_word_t wdata,
    output link_word_t rdata,
    output logic       full,
    output logic       empty
);
    localparam int PW = $clog2(DEPTH + 1);
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [PW-1:0] ptr;
    link_word_t    mem [DEPTH];
    logic [PW-1:0] top_ptr;

    assign top_ptr = ptr - PW'(1);
    assign full    = (ptr == PW'(DEPTH));
    assign empty   = (ptr == '0);
    assign rdata   = mem[IW'(top_ptr)];

    always_ff @(posedge clk) begin
        if (push) mem[IW'(ptr)] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst)       ptr <= '0;
        else if (push) ptr <= ptr + PW'(1);
        else if (pop)  ptr <= ptr - PW'(1);
    end

    // R4
    ptr_bound_chk: assert property (@(posedge clk) disable iff (rst)
        ptr <= PW'(DEPTH));

    // R6
    push_room_chk: assert property (@(posedge clk) disable iff (rst)
        push |-> !full);

    // R7
    pop_data_chk: assert property (@(posedge clk) disable iff (rst)
        pop |-> !empty);
endmodule

// File: rtl/link_ctrl.sv
module link_ctrl
    import link_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       call_req,
    input  logic       ret_req,
    input  addr_t      call_target,
    input  addr_t      cur_pc,
    input  logic       flag_z_in,
    input  logic       flag_c_in,
    input  logic       restore_flags_en,
    input  logic       full,
    input  logic       empty,
    input  link_word_t rdata,
    output logic       push,
    output logic       pop,
    output link_word_t wdata,
    output addr_t      next_pc,
    output logic       next_pc_valid,
    output logic       flags_load,
    output logic       flag_z_out,
    output logic       flag_c_out,
    output logic       stack_err
);
    logic do_call, do_ret, refused;

    assign do_call = call_req;
    assign do_ret  = ret_req & ~call_req;
    assign push    = do_call & ~full;
    assign pop     = do_ret & ~empty;
    assign refused = (do_call & full) | (do_ret & empty);
    assign wdata   = build_link(flag_z_in, flag_c_in, call_target, cur_pc);

    always_ff @(posedge clk) begin
        if (rst) begin
            next_pc       <= '0;
            next_pc_valid <= 1'b0;
            flags_load    <= 1'b0;
            flag_z_out    <= 1'b0;
            flag_c_out    <= 1'b0;
            stack_err     <= 1'b0;
        end else begin
            next_pc_valid <= push | pop;
            flags_load    <= pop & restore_flags_en;
            if (push)     next_pc <= target_of(wdata);
            else if (pop) next_pc <= rdata.ret;
            if (pop && restore_flags_en) begin
                flag_z_out <= rdata.z;
                flag_c_out <= rdata.c;
            end
            if (refused) stack_err <= 1'b1;
        end
    end

    // R2
    call_redirect_chk: assert property (@(posedge clk) disable iff (rst)
        (call_req && !full) |=> (next_pc_valid && next_pc == $past(call_target)));

    // R6
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        (call_req && full) |=> (!next_pc_valid && stack_err));

    // R7
    no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
        (ret_req && !call_req && empty) |=> (!next_pc_valid && stack_err));

    // R8
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        stack_err |=> stack_err);

    // R5
    flags_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !restore_flags_en |=> (!flags_load && flag_z_out == $past(flag_z_out)
                               && flag_c_out == $past(flag_c_out)));

    // R11
    idle_chk: assert property (@(posedge clk) disable iff (rst)
        (!call_req && !ret_req) |=> !next_pc_valid);

    // R10
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!stack_err && !next_pc_valid && !flags_load));
endmodule

// File: rtl/link_stack_unit.sv
module link_stack_unit
    import link_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        call_req,
    input  logic        ret_req,
    input  logic [14:0] call_target,
    input  logic [14:0] cur_pc,
    input  logic        flag_z_in,
    input  logic        flag_c_in,
    input  logic        restore_flags_en,
    output logic [14:0] next_pc,
    output logic        next_pc_valid,
    output logic        flags_load,
    output logic        flag_z_out,
    output logic        flag_c_out,
    output logic        stack_err
);
    logic       push, pop, full, empty;
    link_word_t wdata, rdata;

    link_stack_rf #(.DEPTH(DEPTH)) u_rf (
        .clk   (clk),
        .rst   (rst),
        .push  (push),
        .pop   (pop),
        .wdata (wdata),
        .rdata (rdata),
        .full  (full),
        .empty (empty)
    );

    link_ctrl u_ctrl (
        .clk              (clk),
        .rst              (rst),
        .call_req         (call_req),
        .ret_req          (ret_req),
        .call_target      (call_target),
        .cur_pc           (cur_pc),
        .flag_z_in        (flag_z_in),
        .flag_c_in        (flag_c_in),
        .restore_flags_en (restore_flags_en),
        .full             (full),
        .empty            (empty),
        .rdata            (rdata),
        .push             (push),
        .pop              (pop),
        .wdata            (wdata),
        .next_pc          (next_pc),
        .next_pc_valid    (next_pc_valid),
        .flags_load       (flags_load),
        .flag_z_out       (flag_z_out),
        .flag_c_out       (flag_c_out),
        .stack_err        (stack_err)
    );
endmodule

// File: tb/sim_link_stack_unit.sv
`timescale 1ns/1ps
module sim_link_stack_unit;
    localparam int DEPTH = 16;
    localparam int NVEC  = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        call_req = 1'b0, ret_req = 1'b0;
    logic [14:0] call_target = '0, cur_pc = '0;
    logic        flag_z_in = 1'b0, flag_c_in = 1'b0, restore_flags_en = 1'b0;
    logic [14:0] next_pc;
    logic        next_pc_valid, flags_load, flag_z_out, flag_c_out, stack_err;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    link_stack_unit #(.DEPTH(DEPTH)) u0 (
        .clk(clk), .rst(rst), .call_req(call_req), .ret_req(ret_req),
        .call_target(call_target), .cur_pc(cur_pc),
        .flag_z_in(flag_z_in), .flag_c_in(flag_c_in),
        .restore_flags_en(restore_flags_en),
        .next_pc(next_pc), .next_pc_valid(next_pc_valid),
        .flags_load(flags_load), .flag_z_out(flag_z_out),
        .flag_c_out(flag_c_out), .stack_err(stack_err)
    );

    // op: 0 idle, 1 call, 2 return, 3 call+return
    // {op, target, pc, z, c, restore, exp_valid, exp_pc, exp_load, exp_z, exp_c, exp_err}
    typedef struct packed {
        logic [1:0]  op;
        logic [14:0] tgt;
        logic [14:0] pc;
        logic        z, c, rs;
        logic        ev;
        logic [14:0] epc;
        logic        el, ez, ec, ee;
    } vec_t;

    localparam vec_t VECS [NVEC] = '{
        '{2'd1, 15'h0100, 15'h0010, 1'b1, 1'b0, 1'b0, 1'b1, 15'h0100, 1'b0, 1'b0, 1'b0, 1'b0}, // R2
        '{2'd1, 15'h7FFF, 15'h7FFF, 1'b0, 1'b1, 1'b0, 1'b1, 15'h7FFF, 1'b0, 1'b0, 1'b0, 1'b0}, // R1
        '{2'd2, 15'h0000, 15'h0000, 1'b0, 1'b0, 1'b1, 1'b1, 15'h0000, 1'b1, 1'b0, 1'b1, 1'b0}, // R3 wrap, R5
        '{2'd2, 15'h0000, 15'h0000, 1'b0, 1'b0, 1'b0, 1'b1, 15'h0011, 1'b0, 1'b0, 1'b1, 1'b0}, // R4, R5 hold
        '{2'd0, 15'h1234, 15'h0000, 1'b1, 1'b1, 1'b1, 1'b0, 15'h0011, 1'b0, 1'b0, 1'b1, 1'b0}, // R11
        '{2'd3, 15'h02AA, 15'h0055, 1'b1, 1'b1, 1'b1, 1'b1, 15'h02AA, 1'b0, 1'b0, 1'b1, 1'b0}, // R9
        '{2'd2, 15'h0000, 15'h0000, 1'b0, 1'b0, 1'b1, 1'b1, 15'h0056, 1'b1, 1'b1, 1'b1, 1'b0}, // R9, R1
        '{2'd0, 15'h0000, 15'h0000, 1'b0, 1'b0, 1'b0, 1'b0, 15'h0056, 1'b0, 1'b1, 1'b1, 1'b0}  // R11
    };

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic drive(logic cr, logic rr, logic [14:0] t, logic [14:0] p,
                         logic z, logic c, logic rs);
        @(negedge clk);
        call_req = cr; ret_req = rr; call_target = t; cur_pc = p;
        flag_z_in = z; flag_c_in = c; restore_flags_en = rs;
        @(posedge clk);
        #2;
        call_req = 1'b0; ret_req = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #2;
        rst = 1'b0;
    endtask

    initial begin
        do_reset();
        chk("R10 valid", 32'(next_pc_valid), 32'd0);
        chk("R10 err", 32'(stack_err), 32'd0);
        chk("R10 flags", {30'd0, flag_z_out, flag_c_out}, 32'd0);

        for (int i = 0; i < NVEC; i++) begin
            drive(VECS[i].op[0], VECS[i].op[1], VECS[i].tgt, VECS[i].pc,
                  VECS[i].z, VECS[i].c, VECS[i].rs);
            chk($sformatf("vec%0d valid", i), 32'(next_pc_valid), 32'(VECS[i].ev));
            if (VECS[i].ev)
                chk($sformatf("vec%0d pc", i), 32'(next_pc), 32'(VECS[i].epc));
            chk($sformatf("vec%0d load", i), 32'(flags_load), 32'(VECS[i].el));
            chk($sformatf("vec%0d flags", i), {30'd0, flag_z_out, flag_c_out},
                {30'd0, VECS[i].ez, VECS[i].ec});
            chk($sformatf("vec%0d err", i), 32'(stack_err), 32'(VECS[i].ee));
        end

        // R6: fill stack, then one more call
        for (int i = 0; i < DEPTH; i++) begin
            drive(1'b1, 1'b0, 15'(16'h0200 + i), 15'(i), i[0], i[1], 1'b0);
            chk("R2 fill redirect", 32'(next_pc), 32'(16'h0200 + i));
        end
        drive(1'b1, 1'b0, 15'h0333, 15'h0099, 1'b0, 1'b0, 1'b0);
        chk("R6 no redirect", 32'(next_pc_valid), 32'd0);
        chk("R6 err", 32'(stack_err), 32'd1);
        // R4: drain in reverse order, flags restored
        for (int i = DEPTH - 1; i >= 0; i--) begin
            drive(1'b0, 1'b1, 15'h0, 15'h0, 1'b0, 1'b0, 1'b1);
            chk("R4 lifo pc", 32'(next_pc), 32'(i + 1));
            chk("R1 flags", {30'd0, flag_z_out, flag_c_out}, {30'd0, i[0], i[1]});
        end
        drive(1'b0, 1'b1, 15'h0, 15'h0, 1'b0, 1'b0, 1'b1);
        chk("R7 no redirect", 32'(next_pc_valid), 32'd0);
        chk("R8 sticky", 32'(stack_err), 32'd1);
        drive(1'b1, 1'b0, 15'h0444, 15'h0001, 1'b0, 1'b0, 1'b0);
        chk("R8 sticky after call", 32'(stack_err), 32'd1);

        do_reset();
        chk("R10 err cleared", 32'(stack_err), 32'd0);
        drive(1'b0, 1'b1, 15'h0, 15'h0, 1'b0, 1'b0, 1'b0);
        chk("R10 stack emptied / R7", 32'(next_pc_valid), 32'd0);
        chk("R7 err", 32'(stack_err), 32'd1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule